// File: doc/BRIEF.md
# Multiply-Add-Logic Datapath

This block is a 48-bit arithmetic and logic stage for signal-processing pipelines. A signed 25 x 18 multiplier produces its product as two partial products, and three operand selectors (X, Y and Z) choose the adder inputs. The sources are the two partial products, the zero-extended concatenation of A and B, a 48-bit C operand, the registered result P, a cascade input from a neighbouring stage, and constants. A 7-bit source-select word sets the three selectors. A 4-bit function code then picks one of these operations:

- add the sum X + Y + carry-in to Z;
- subtract that sum from Z;
- subtract Z from the sum, less one;
- one of seven bitwise functions between X and Z.

For the bitwise functions the Y selector supplies all zeros or all ones, and that choice picks between the two halves of a function pair.

An optional input register stage captures the operands, the control words and the write enable. The result register P has a write enable and a synchronous clear. When Z selects P the stage becomes a multiply-accumulator. With full-width operands it has 5 guard bits, so 32 worst-case products can be summed without overflow.

Top module: `mal_slice`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `p` to zero and `cout` to 0 at that edge.
- R2: An operation issued with `ce` low leaves `p` and `cout` unchanged.
- R3: With X select = 1 and Y select = 1 (`opsel[1:0]`=1, `opsel[3:2]`=1), Z select = 0 (`opsel[6:4]`=0), `alufn`=0000 and `cin`=0, `p` equals the 43-bit signed product of `a` and `b`, sign-extended to 48 bits.
- R4: With `alufn`=0000 (and for any code not listed in R5 to R7), `p` = Z + X + Y + `cin` mod 2^48. The selects are:
  - X select `opsel[1:0]`: 0 = zero, 1 = low partial product, 2 = P, 3 = {`a`,`b`} zero-extended.
  - Y select `opsel[3:2]`: 0 = zero, 1 = high partial product, 2 = all ones, 3 = `c`.
  - Z select `opsel[6:4]`: 1 = `pcin`, 2 = P, 3 = `c`, any other value = zero.
- R5: With `alufn`=0011, `p` = Z - (X + Y + `cin`) mod 2^48.
- R6: With `alufn`=0001, `p` = -Z + (X + Y + `cin`) - 1 mod 2^48.
- R7: Bitwise codes give the results below, where "Y ones" means Y select = 2 and any other Y select counts as zeros. `cout` is 0 for all of them.

  | `alufn` | Y zeros | Y ones |
  |---|---|---|
  | 0100 | X xor Z | X xnor Z |
  | 0101 | X xnor Z | X xor Z |
  | 1100 | X and Z | X or Z |
  | 1110 | X nand Z | X nor Z |
  | 1101 | not Z | not X |

- R8: For add, subtract and inverted subtract, `cout` is bit 48 of the 49-bit sum used: {0,Z}+{0,S}, {0,Z}+{0,~S}+1 or {0,~Z}+{0,S} respectively, where S = X+Y+`cin`. `cout` is 0 whenever X select = 1 (multiply).
- R9: With `IN_REG`=1, an operation applied before rising edge n appears on `p` after edge n+1, and `p` still holds the earlier value after edge n.
- R10: Thirty-two accumulations (Z = P) of the product (-2^24) x (-2^17), starting from P = 0, give exactly 2^46 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the input stage and of P |
| ce | input | 1 | Write enable for P, carried along with the operation |
| a | input | 25 | Signed multiplicand, upper part of {a,b} |
| b | input | 18 | Signed multiplier, lower part of {a,b} |
| c | input | 48 | C operand |
| pcin | input | 48 | Cascade input from a neighbouring stage |
| cin | input | 1 | Carry-in added to X + Y |
| opsel | input | 7 | Source selects: [1:0] X, [3:2] Y, [6:4] Z |
| alufn | input | 4 | Arithmetic or bitwise function code |
| p | output | 48 | Registered result |
| cout | output | 1 | Registered carry-out |

## Verification
With the input stage enabled, the bench drives every operation between clock edges, and its result is due on `p` and `cout` just after the second following rising edge. Each scoreboard item records the cycle count at which it falls due. The monitor compares an item only at the falling edge of that cycle. For the latency check, the bench also queues the old P value one cycle earlier, which confirms the result has not arrived early. Accumulation runs back to back at one operation per cycle, so the bench's reference P advances in issue order, matching the register's update order.

// File: rtl/mal_pkg.sv
package mal_pkg;
    localparam int AW   = 25;
    localparam int BW   = 18;
    localparam int PW   = 48;
    localparam int OSW  = 7;
    localparam int ALW  = 4;
    localparam int MW   = AW + BW;
    localparam int BLO  = BW / 2;
    localparam int BHI  = BW - BLO;

    localparam logic [1:0] XS_ZERO = 2'd0, XS_MUL = 2'd1, XS_P = 2'd2, XS_AB = 2'd3;
    localparam logic [1:0] YS_ZERO = 2'd0, YS_MUL = 2'd1, YS_ONES = 2'd2, YS_C = 2'd3;
    localparam logic [2:0] ZS_PCIN = 3'd1, ZS_P = 3'd2, ZS_C = 3'd3;

    localparam logic [ALW-1:0] AL_ADD = 4'b0000, AL_INVSUB = 4'b0001, AL_SUB = 4'b0011;
    localparam logic [ALW-1:0] AL_XOR = 4'b0100, AL_XNOR = 4'b0101, AL_AND = 4'b1100;
    localparam logic [ALW-1:0] AL_NOT = 4'b1101, AL_NAND = 4'b1110;

    typedef struct packed {
        logic            ce;
        logic [AW-1:0]   a;
        logic [BW-1:0]   b;
        logic [PW-1:0]   c;
        logic [PW-1:0]   pcin;
        logic            cin;
        logic [OSW-1:0]  opsel;
        logic [ALW-1:0]  alu;
    } stage_t;

    typedef struct packed {
        logic [PW-1:0] p;
        logic          cout;
    } result_t;
endpackage

// File: rtl/mal_inreg.sv
module mal_inreg
    import mal_pkg::*;
#(
    parameter bit IN_REG = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t stg_d,
    output stage_t stg_q
);
    generate
        if (IN_REG) begin : g_reg
            stage_t hold_d, hold_q;
            always_comb begin
                hold_d = stg_d;
                if (rst) hold_d = '0;
            end
            always_ff @(posedge clk) hold_q <= hold_d;
            assign stg_q = hold_q;
        end else begin : g_pass
            assign stg_q = stg_d;
        end
    endgenerate
endmodule

// File: rtl/mal_mult.sv
module mal_mult
    import mal_pkg::*;
(
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [PW-1:0] pp_lo,
    output logic [PW-1:0] pp_hi
);
    logic signed [MW-1:0] a_ext, blo_ext, bhi_ext, m_lo, m_hi_raw, m_hi;

    always_comb begin
        a_ext    = {{BW{a[AW-1]}}, a};
        blo_ext  = {{(MW-BLO){1'b0}}, b[BLO-1:0]};
        bhi_ext  = {{(MW-BHI){b[BW-1]}}, b[BW-1:BLO]};
        m_lo     = a_ext * blo_ext;
        m_hi_raw = a_ext * bhi_ext;
        m_hi     = m_hi_raw <<< BLO;
        pp_lo    = {{(PW-MW){m_lo[MW-1]}}, m_lo};
        pp_hi    = {{(PW-MW){m_hi[MW-1]}}, m_hi};
    end
endmodule

// File: rtl/mal_alu.sv
module mal_alu
    import mal_pkg::*;
(
    input  stage_t        stg,
    input  logic [PW-1:0] pp_lo,
    input  logic [PW-1:0] pp_hi,
    input  logic [PW-1:0] p_fb,
    output result_t       res
);
    logic [PW-1:0] xv, yv, zv, sum;
    logic [PW:0]   wide;
    logic          y_ones, mul_mode;

    always_comb begin
        unique case (stg.opsel[1:0])
            XS_MUL:  xv = pp_lo;
            XS_P:    xv = p_fb;
            XS_AB:   xv = {{(PW-MW){1'b0}}, stg.a, stg.b};
            default: xv = '0;
        endcase
        unique case (stg.opsel[3:2])
            YS_MUL:  yv = pp_hi;
            YS_ONES: yv = '1;
            YS_C:    yv = stg.c;
            default: yv = '0;
        endcase
        case (stg.opsel[6:4])
            ZS_PCIN: zv = stg.pcin;
            ZS_P:    zv = p_fb;
            ZS_C:    zv = stg.c;
            default: zv = '0;
        endcase

        y_ones   = (stg.opsel[3:2] == YS_ONES);
        mul_mode = (stg.opsel[1:0] == XS_MUL);
        sum      = xv + yv + {{(PW-1){1'b0}}, stg.cin};
        wide     = {1'b0, zv} + {1'b0, sum};

        unique case (stg.alu)
            AL_SUB:    wide = {1'b0, zv} + {1'b0, ~sum} + {{PW{1'b0}}, 1'b1};
            AL_INVSUB: wide = {1'b0, ~zv} + {1'b0, sum};
            AL_XOR:    wide = {1'b0, y_ones ? ~(xv ^ zv) : (xv ^ zv)};
            AL_XNOR:   wide = {1'b0, y_ones ? (xv ^ zv) : ~(xv ^ zv)};
            AL_AND:    wide = {1'b0, y_ones ? (xv | zv) : (xv & zv)};
            AL_NAND:   wide = {1'b0, y_ones ? ~(xv | zv) : ~(xv & zv)};
            AL_NOT:    wide = {1'b0, y_ones ? ~xv : ~zv};
            default:   ;
        endcase

        res.p    = wide[PW-1:0];
        res.cout = wide[PW] & ~mul_mode;
    end
endmodule

// File: rtl/mal_slice.sv
module mal_slice
    import mal_pkg::*;
#(
    parameter bit IN_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic [AW-1:0]  a,
    input  logic [BW-1:0]  b,
    input  logic [PW-1:0]  c,
    input  logic [PW-1:0]  pcin,
    input  logic           cin,
    input  logic [OSW-1:0] opsel,
    input  logic [ALW-1:0] alufn,
    output logic [PW-1:0]  p,
    output logic           cout
);
    stage_t  st_d, st_q;
    result_t alu_res, out_d, out_q;
    logic [PW-1:0] pp_lo, pp_hi;

    always_comb begin
        st_d.ce    = ce;
        st_d.a     = a;
        st_d.b     = b;
        st_d.c     = c;
        st_d.pcin  = pcin;
        st_d.cin   = cin;
        st_d.opsel = opsel;
        st_d.alu   = alufn;
    end

    mal_inreg #(.IN_REG(IN_REG)) u_inreg (
        .clk(clk), .rst(rst), .stg_d(st_d), .stg_q(st_q)
    );

    mal_mult u_mult (
        .a(st_q.a), .b(st_q.b), .pp_lo(pp_lo), .pp_hi(pp_hi)
    );

    mal_alu u_alu (
        .stg(st_q), .pp_lo(pp_lo), .pp_hi(pp_hi), .p_fb(out_q.p), .res(alu_res)
    );

    always_comb begin
        out_d = out_q;
        if (st_q.ce) out_d = alu_res;
        if (rst)     out_d = '0;
    end

    always_ff @(posedge clk) out_q <= out_d;

    assign p    = out_q.p;
    assign cout = out_q.cout;
endmodule

// File: rtl/mal_chk.sv
module mal_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_ce,
    input logic        s_cin,
    input logic [6:0]  s_opsel,
    input logic [3:0]  s_alu,
    input logic [47:0] p,
    input logic        cout
);
    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (p == '0 && !cout)); // R1

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !s_ce |=> ($stable(p) && $stable(cout))); // R2

    AST_ZERO_SOURCES: assert property (@(posedge clk) disable iff (rst)
        (s_ce && s_opsel == 7'd0 && s_alu == 4'b0000 && !s_cin) |=> (p == '0)); // R4

    AST_SELF_XOR: assert property (@(posedge clk) disable iff (rst)
        (s_ce && s_opsel == 7'b010_00_10 && s_alu == 4'b0100) |=> (p == '0 && !cout)); // R7

    AST_MUL_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (s_ce && s_opsel[1:0] == 2'd1) |=> !cout); // R8
endmodule

bind mal_slice mal_chk u_chk (
    .clk(clk), .rst(rst), .s_ce(st_q.ce), .s_cin(st_q.cin),
    .s_opsel(st_q.opsel), .s_alu(st_q.alu), .p(p), .cout(cout)
);

// File: tb/sim_mal_slice.sv
`timescale 1ns/1ps
module sim_mal_slice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic [24:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [47:0] pcin = '0;
    logic        cin = 1'b0;
    logic [6:0]  opsel = '0;
    logic [3:0]  alufn = '0;
    logic [47:0] p;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int          due;
        logic [47:0] p;
        logic        co;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [47:0] m_p  = '0;
    logic        m_co = 1'b0;

    mal_slice u0 (.clk(clk), .rst(rst), .ce(ce), .a(a), .b(b), .c(c), .pcin(pcin),
                  .cin(cin), .opsel(opsel), .alufn(alufn), .p(p), .cout(cout));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [48:0] model(input logic [24:0] ia, input logic [17:0] ib,
            input logic [47:0] ic, input logic [47:0] ipc, input logic ici,
            input logic [6:0] os, input logic [3:0] al, input logic [47:0] pp);
        logic [47:0] x, y, z, s, r;
        logic signed [47:0] sa, sbv;
        logic co, yo;
        sa  = {{23{ia[24]}}, ia};
        sbv = {{30{ib[17]}}, ib};
        if (os[1:0] == 2'd1 && os[3:2] == 2'd1) begin
            x = sa * sbv;
            y = '0;
        end else begin
            case (os[1:0])
                2'd2: x = pp;
                2'd3: x = {5'b0, ia, ib};
                default: x = '0;
            endcase
            case (os[3:2])
                2'd2: y = '1;
                2'd3: y = ic;
                default: y = '0;
            endcase
        end
        case (os[6:4])
            3'd1: z = ipc;
            3'd2: z = pp;
            3'd3: z = ic;
            default: z = '0;
        endcase
        yo = (os[3:2] == 2'd2);
        s  = x + y + {47'b0, ici};
        co = 1'b0;
        case (al)
            4'b0011: {co, r} = {1'b0, z} + {1'b0, ~s} + 49'd1;
            4'b0001: {co, r} = {1'b0, ~z} + {1'b0, s};
            4'b0100: r = yo ? ~(x ^ z) : (x ^ z);
            4'b0101: r = yo ? (x ^ z) : ~(x ^ z);
            4'b1100: r = yo ? (x | z) : (x & z);
            4'b1110: r = yo ? ~(x | z) : ~(x & z);
            4'b1101: r = yo ? ~x : ~z;
            default: {co, r} = {1'b0, z} + {1'b0, s};
        endcase
        if (os[1:0] == 2'd1) co = 1'b0;
        return {co, r};
    endfunction

    task automatic check_now(input string tag, input logic [47:0] ep, input logic eco);
        checks++;
        if (p !== ep || cout !== eco) begin
            fails++;
            $display("FAIL %s: p=%h cout=%b expected p=%h cout=%b", tag, p, cout, ep, eco);
        end
    endtask

    task automatic op(input string tag, input logic [24:0] ia, input logic [17:0] ib,
            input logic [47:0] ic, input logic [47:0] ipc, input logic ici,
            input logic [6:0] os, input logic [3:0] al, input logic ice);
        item_t it;
        logic [48:0] r;
        a = ia; b = ib; c = ic; pcin = ipc; cin = ici; opsel = os; alufn = al; ce = ice;
        if (ice) begin
            r = model(ia, ib, ic, ipc, ici, os, al, m_p);
            m_co = r[48];
            m_p  = r[47:0];
        end
        it.due = cyc + 2; it.p = m_p; it.co = m_co; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic drain();
        ce = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() != 0 && sb[0].due == cyc) begin
                item_t it;
                it = sb.pop_front();
                check_now(it.tag, it.p, it.co);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_now("R1 reset state", '0, 1'b0);

        op("R3 mul 3x5",        25'd3, 18'd5, '0, '0, 1'b0, 7'b000_01_01, 4'b0000, 1'b1);
        op("R3 mul -1x1",       '1, 18'd1, '0, '0, 1'b0, 7'b000_01_01, 4'b0000, 1'b1);
        op("R3 mul min x min",  25'h1000000, 18'h20000, '0, '0, 1'b0, 7'b000_01_01, 4'b0000, 1'b1);
        op("R3 mul mixed",      25'd12345, -18'sd678, '0, '0, 1'b0, 7'b000_01_01, 4'b0000, 1'b1);
        op("R8 mul carry zero", '1, '1, '1, '0, 1'b1, 7'b011_01_01, 4'b0000, 1'b1);

        op("R4 ab+c+pcin+cin",  25'h0ABCDE, 18'h12345, 48'h0000_1234_5678, 48'h7000_0000_0001, 1'b1, 7'b001_11_11, 4'b0000, 1'b1);
        op("R4 c plus ones",    '0, '0, 48'h0000_0000_1000, '0, 1'b0, 7'b011_10_00, 4'b0000, 1'b1);
        op("R8 add carry out",  '0, 18'd1, '1, '0, 1'b0, 7'b011_00_11, 4'b0000, 1'b1);
        op("R5 c minus ab",     25'd7, 18'd9, 48'd1000000000000, '0, 1'b0, 7'b011_00_11, 4'b0011, 1'b1);
        op("R5 sub negative",   25'd1, '0, 48'd5, '0, 1'b1, 7'b011_00_11, 4'b0011, 1'b1);
        op("R6 inv subtract",   25'd2, 18'd3, 48'd100, '0, 1'b0, 7'b011_00_11, 4'b0001, 1'b1);
        op("R6 inv sub cin",    '0, 18'd50, 48'd20, '0, 1'b1, 7'b011_00_11, 4'b0001, 1'b1);

        foreach (sb[i]) ;
        begin
            logic [3:0] codes [5] = '{4'b0100, 4'b0101, 4'b1100, 4'b1110, 4'b1101};
            for (int k = 0; k < 5; k++) begin
                for (int yo = 0; yo < 2; yo++) begin
                    op($sformatf("R7 logic code %b yones %0d", codes[k], yo),
                       25'h155AA55, 18'h2C3C3, 48'hF0F0_1234_CC33, '0, 1'b0,
                       {3'b011, (yo != 0) ? 2'b10 : 2'b00, 2'b11}, codes[k], 1'b1);
                end
            end
        end

        op("R2 ce low keeps p", 25'd99, 18'd99, 48'd5, '0, 1'b0, 7'b011_00_11, 4'b0000, 1'b0);
        op("R2 ce low again",   '1, '1, '1, '1, 1'b1, 7'b001_11_11, 4'b0011, 1'b0);
        drain();

        begin : r9_latency
            item_t it;
            it.due = cyc + 1; it.p = m_p; it.co = m_co; it.tag = "R9 not early";
            sb.push_back(it);
            op("R9 due two edges", 25'd4, 18'd4, 48'd77, '0, 1'b0, 7'b011_00_11, 4'b0000, 1'b1);
        end

        op("R10 clear p", '0, '0, '0, '0, 1'b0, 7'b000_00_00, 4'b0000, 1'b1);
        for (int k = 0; k < 32; k++)
            op("R10 accumulate", 25'h1000000, 18'h20000, '0, '0, 1'b0, 7'b010_01_01, 4'b0000, 1'b1);
        drain();
        check_now("R10 32 products exact", 48'h4000_0000_0000, 1'b0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_p = '0; m_co = 1'b0;
        check_now("R1 reset mid run", '0, 1'b0);

        op("R7 p xor p", '0, '0, '0, '0, 1'b0, 7'b010_00_10, 4'b0100, 1'b1);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule